// File: doc/BRIEF.md
# Operation Timing Obfuscation Padder

This block sits between a storage controller and its memory array interface. Its job is to hide which kind of operation has just run from anyone who measures the time between an operation starting and its completion becoming visible. The block registers an operation start together with an operation kind. It then waits for the array's internal completion. After that it may stretch the operation and always adds jitter before it raises a single external completion pulse.

A fast operation may be stretched to a programmable slowest-operation length. Whether this happens depends on a 4-bit probability threshold compared against pseudo-random bits. Stretching never shortens an operation. After the base duration, every operation receives a further 0 to 15 dummy cycles drawn from the same random source, whatever its kind. Only one operation is in flight at a time: starts are not accepted until the external completion has been issued.

Top module: `op_timing_pad`

## Requirements
- R1: After reset, ext_done_o and busy_o are low.
- R2: Counting the edge that accepts start_i as edge 0, an operation whose int_done_i is sampled high at edge L (L >= 1) and that is not stretched raises ext_done_o in the cycle after edge L + J, where J is the jitter value.
- R3: A stretched operation with L below slow_len_i (sampled at start) completes internally at edge slow_len_i instead of L, so ext_done_o follows edge slow_len_i + J.
- R4: Stretching never shortens: a stretch-selected operation with L >= slow_len_i ends its base duration at edge L.
- R5: An operation whose kind_i equals SLOW_KIND (default 2) is never stretched.
- R6: J equals bits [7:4] of the random register at the acceptance cycle and is added to every operation, including J = 0.
- R7: ext_done_o is a single-cycle pulse. busy_o is high from the cycle after acceptance through the ext_done_o cycle, and low in the following cycle.
- R8: start_i while busy_o is high is ignored and leaves the running operation's timing unchanged. int_done_i is only acted on while waiting for the internal completion.
- R9: The random register is a 16-bit Fibonacci LFSR. Its reset value is SEED (default 16'hACE1). On every clock it shifts left, taking in the XOR of bits 15, 13, 12 and 10. An operation is selected for stretching when bits [3:0] at the acceptance cycle are less than pad_prob_i. A pad_prob_i of 0 never stretches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Operation start request |
| kind_i | input | KW | Operation kind |
| int_done_i | input | 1 | Internal completion from the array |
| slow_len_i | input | CW | Slowest-operation duration in cycles |
| pad_prob_i | input | 4 | Stretch probability threshold |
| busy_o | output | 1 | Operation in flight |
| ext_done_o | output | 1 | Externally visible completion pulse |

## Verification
The bench keeps its own LFSR model from the R9 definition. From it, each operation's due completion edge is worked out as the base end (L, or slow_len_i when stretched and longer) plus J. The bench drives inputs on falling edges and counts rising edges from the acceptance edge. It samples ext_done_o and busy_o on the falling edge after each rising edge. It then compares the edge at which the pulse appears, and how many cycles it lasts, against that due edge. Ignored starts are injected mid-operation, and the same timing comparison must still hold.

// File: rtl/op_timing_pad.sv
module op_timing_pad #(
  parameter int CW = 16,
  parameter int KW = 2,
  parameter int SLOW_KIND = 2,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [KW-1:0] kind_i,
  input  logic          int_done_i,
  input  logic [CW-1:0] slow_len_i,
  input  logic [3:0]    pad_prob_i,
  output logic          busy_o,
  output logic          ext_done_o
);
  localparam logic [KW-1:0] SLOWK = KW'(SLOW_KIND);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_STRETCH, S_JIT, S_DONE} st_t;

  st_t         st;
  logic [15:0] lfsr;
  logic [CW-1:0] cnt, slow_q;
  logic [3:0]  jit;
  logic        pad_q;

  wire fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {lfsr[14:0], fb};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      slow_q <= '0;
      jit    <= '0;
      pad_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st     <= S_RUN;
          cnt    <= CW'(1);
          slow_q <= slow_len_i;
          jit    <= lfsr[7:4];
          pad_q  <= (lfsr[3:0] < pad_prob_i) && (kind_i != SLOWK);
        end
        S_RUN: begin
          if (int_done_i) begin
            if (pad_q && cnt < slow_q) begin
              st  <= S_STRETCH;
              cnt <= cnt + 1'b1;
            end else if (jit == 4'd0) begin
              st <= S_DONE;
            end else begin
              st  <= S_JIT;
              jit <= jit - 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STRETCH: begin
          if (cnt >= slow_q) begin
            if (jit == 4'd0) st <= S_DONE;
            else begin
              st  <= S_JIT;
              jit <= jit - 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_JIT: begin
          if (jit == 4'd0) st <= S_DONE;
          else             jit <= jit - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (st != S_IDLE);
  assign ext_done_o = (st == S_DONE);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ext_done_o |=> !ext_done_o);

  a_r7_busy_through_done: assert property (@(posedge clk) disable iff (!rst_n)
    ext_done_o |=> !busy_o);

  a_r9_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'd0);

  a_r3_stretch_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STRETCH) |-> (cnt <= slow_q && pad_q));

  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ext_done_o) |=> busy_o);

  a_r2_done_from_idle_never: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |=> !ext_done_o);
endmodule

// File: tb/op_timing_pad_tb.sv
module op_timing_pad_tb;
  localparam int CW = 16;
  localparam int KW = 2;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [KW-1:0] kind_i = '0;
  logic int_done_i = 1'b0;
  logic [CW-1:0] slow_len_i = '0;
  logic [3:0] pad_prob_i = '0;
  logic busy_o, ext_done_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] model;

  always #2.5 clk = ~clk;

  op_timing_pad #(.CW(CW), .KW(KW), .SLOW_KIND(2), .SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
    .int_done_i(int_done_i), .slow_len_i(slow_len_i), .pad_prob_i(pad_prob_i),
    .busy_o(busy_o), .ext_done_o(ext_done_o));

  // R9 reference sequence
  always @(posedge clk) begin
    if (!rst_n) model <= SEED;
    else model <= {model[14:0], model[15] ^ model[13] ^ model[12] ^ model[10]};
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [KW-1:0] kind, input int len,
                        input int slow, input logic [3:0] prob, input int stray);
    logic [15:0] m;
    logic pad;
    int j, b, e, first, ndone, busy_gap, after;
    @(negedge clk);
    start_i = 1'b1; kind_i = kind; slow_len_i = CW'(slow); pad_prob_i = prob;
    m = model;
    pad = (m[3:0] < prob) && (kind != 2'd2);
    j = int'(m[7:4]);
    b = (pad && len < slow) ? slow : len;
    e = b + j;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    first = -1; ndone = 0; busy_gap = 0; after = 1;
    for (int k = 1; k <= e + 2; k++) begin
      int_done_i = (k == len);
      if (stray > 0 && k == stray) begin start_i = 1'b1; kind_i = 2'd2; end
      @(posedge clk);
      @(negedge clk);
      int_done_i = 1'b0;
      start_i = 1'b0;
      if (ext_done_o) begin
        ndone++;
        if (first < 0) first = k;
      end
      if (k <= e && !busy_o) busy_gap++;
      if (k == e + 1) after = busy_o;
      // a late int_done pulse after completion must not matter (R8)
    end
    check({tag, " done edge"}, first, e);
    check("R7 pulse width", ndone, 1);
    check("R7 busy during op", busy_gap, 0);
    check("R7 busy low after done", int'(after), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 ext_done after reset", int'(ext_done_o), 0);
    check("R1 busy after reset", int'(busy_o), 0);
  endtask

  task automatic t_no_pad;
    run_op("R2 prob0 L=5", 2'd0, 5, 40, 4'd0, 0);
    run_op("R2 prob0 L=1", 2'd1, 1, 40, 4'd0, 0);
    run_op("R6 jitter prob0 L=12", 2'd0, 12, 40, 4'd0, 0);
  endtask

  task automatic t_pad;
    for (int i = 0; i < 6; i++) run_op("R3 prob15 stretch", 2'd0, 3 + i, 30, 4'd15, 0);
    run_op("R3 R9 prob8 mixed", 2'd1, 4, 30, 4'd8, 0);
    run_op("R3 R9 prob8 mixed", 2'd1, 6, 30, 4'd8, 0);
  endtask

  task automatic t_no_shorten;
    run_op("R4 long op L=35 slow=20", 2'd0, 35, 20, 4'd15, 0);
    run_op("R4 equal L=20 slow=20", 2'd1, 20, 20, 4'd15, 0);
  endtask

  task automatic t_slow_kind;
    run_op("R5 slow kind L=4", 2'd2, 4, 30, 4'd15, 0);
    run_op("R5 slow kind L=9", 2'd2, 9, 30, 4'd15, 0);
  endtask

  task automatic t_stray_start;
    run_op("R8 stray start", 2'd0, 8, 25, 4'd15, 3);
    run_op("R8 stray start late", 2'd1, 6, 12, 4'd0, 7);
  endtask

  task automatic t_stray_done;
    @(negedge clk);
    int_done_i = 1'b1;
    @(negedge clk);
    int_done_i = 1'b0;
    check("R8 int_done in idle", int'(busy_o), 0);
    check("R8 int_done in idle ext", int'(ext_done_o), 0);
    run_op("R8 after idle int_done", 2'd0, 4, 10, 4'd0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_no_pad;
    t_pad;
    t_no_shorten;
    t_slow_kind;
    t_stray_start;
    t_stray_done;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule